// File: doc/BRIEF.md
# Multiplexed-Address DRAM Array Emulator

This block behaves like an asynchronous dynamic memory with a small internal array, but everything happens on one fast system clock. The active-low row strobe, column strobe, write enable and output enable are sampled on each rising clock edge. A strobe's falling edge is seen when it is sampled low after having been sampled high. One shared address bus carries the row number when the row strobe falls and the column number when the column strobe falls. The data path is split into a data-in bus, a data-out bus and a drive-enable output, so the block can sit behind a pad ring or a bus model.

Several column pulses may follow while the row strobe stays low. They can address columns freely (page mode), or in nibble mode they step through an aligned group of four columns that the block generates itself. An extended-output option keeps read data on the bus after the column strobe rises. Two timing minimums are integer clock counts: the row precharge time and the row-to-column delay. A strobe edge that breaks either one is dropped and sets a sticky error flag. Refresh, cell decay and analog timing are not modelled.

Top module: `mxdram_emu`

## Requirements
- R1: An accepted row-strobe falling edge latches `addr[ROW_W-1:0]` as the open row. That row stays open until the row strobe is sampled high. Every column access before then uses that row.
- R2: An accepted column-strobe falling edge with `we_n` sampled low writes `dq_in` into the cell at (open row, selected column) on that same clock edge.
- R3: An accepted column-strobe falling edge with `we_n` sampled high is a read. After that edge, `dq_out` shows the cell's content and `dq_oe` is high, provided `oe_n` is low. `dq_oe` is low whenever `oe_n` is high.
- R4: When read data is not valid, `dq_out` is all zeros and `dq_oe` is low. If `edo_en` is low, valid data is dropped after the first edge at which the column strobe is sampled high. In every mode, valid data is dropped after any edge at which the row strobe is sampled high.
- R5: Page mode: with the row strobe held low, each column-strobe falling edge takes a new column from `addr[COL_W-1:0]` and does not reopen the row.
- R6: Nibble mode (`nibble_en` high): the first access after a row opens takes its column from the address bus. The next three accesses ignore the bus and use the previous column with its two low bits incremented modulo 4, the upper bits kept. The fifth access takes the bus again, and so on. The count restarts whenever a row is accepted.
- R7: With `edo_en` high, read data stays valid after the column strobe rises. It is replaced by the next read, and cleared by a write access or by the row strobe being sampled high.
- R8: A row-strobe falling edge is accepted only if the row strobe was sampled high on at least `T_RP` consecutive edges just before it. Otherwise no row opens, `timing_err` sets, and column pulses until the next accepted row perform no access.
- R9: A column-strobe falling edge is accepted only if it comes at least `T_RCD` edges after the accepted row falling edge. A column fall on the same edge as a row fall is always too early. An early column fall performs no access and sets `timing_err`.
- R10: A column-strobe falling edge while the row strobe is sampled high performs no access, produces no output and sets no error.
- R11: Reset clears `dq_oe`, `dq_out` and `timing_err`, treats both strobes as high, and leaves the array contents unchanged. Once set, `timing_err` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Shared row/column address bus |
| ras_n | input | 1 | Active-low row strobe |
| cas_n | input | 1 | Active-low column strobe |
| we_n | input | 1 | Active-low write enable, sampled at the column fall |
| oe_n | input | 1 | Active-low output enable |
| nibble_en | input | 1 | Selects nibble column sequencing |
| edo_en | input | 1 | Selects extended output hold |
| dq_in | input | DATA_W | Write data |
| dq_out | output | DATA_W | Read data, zero when no read is valid |
| dq_oe | output | 1 | High while the block drives read data |
| timing_err | output | 1 | Sticky precharge / row-to-column violation flag |

## Verification
A wrong open-row register or nibble column counter does not show until a later read, one clock after its column fall, when `dq_out` carries another cell's value. For that reason every written cell is read back in a later scenario. A faulty precharge or row-to-column counter shows up in one of two ways: on the offending edge `timing_err` fails to rise (or rises falsely), or a write that should have been dropped later reads back changed. A read-valid bit that is held or cleared wrongly shows on `dq_oe` one clock after the edge where the column or row strobe is sampled high. The bench therefore compares all three outputs against a reference model after every clock edge.

// File: rtl/mxd_pkg.sv
package mxd_pkg;

    // lane numbers inside the strobe edge detector
    localparam int STB_RAS = 0;
    localparam int STB_CAS = 1;
    localparam int STB_N   = 2;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_t;

    // decoded strobe events for one clock edge
    typedef struct packed {
        logic ras_ok;     // row fall accepted
        logic ras_bad;    // row fall during precharge
        logic cas_acc;    // column fall performs an access
        logic cas_early;  // column fall before row-to-column delay
    } strobe_dec_t;

    // nibble sequencing: low two column bits wrap inside an aligned group
    function automatic logic [1:0] nib_wrap_inc(input logic [1:0] low);
        return low + 2'd1;
    endfunction

endpackage

// File: rtl/mxd_edge.sv
module mxd_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sig_n,
    output logic [N-1:0] q_n,
    output logic [N-1:0] fall
);
    for (genvar i = 0; i < N; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) q_n[i] <= 1'b1;
            else     q_n[i] <= sig_n[i];
        end
        assign fall[i] = q_n[i] & ~sig_n[i];
    end
endmodule

// File: rtl/mxd_gap_timer.sv
module mxd_gap_timer #(
    parameter int LIMIT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic ready
);
    localparam int            CW    = (LIMIT > 1) ? $clog2(LIMIT + 1) : 1;
    localparam logic [CW-1:0] START = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= START;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign ready = (cnt == '0);
endmodule

// File: rtl/mxd_cell_array.sv
module mxd_cell_array #(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int IDX_W = ROW_W + COL_W;
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] cells [DEPTH];
    logic [IDX_W-1:0]  idx;

    assign idx = {row, col};

    always_ff @(posedge clk) begin
        if (wr_en) cells[idx] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= cells[idx];
    end
endmodule

// File: rtl/mxdram_emu.sv
module mxdram_emu
    import mxd_pkg::*;
#(
    parameter  int ROW_W  = 4,
    parameter  int COL_W  = 4,
    parameter  int DATA_W = 8,
    parameter  int T_RP   = 3,
    parameter  int T_RCD  = 2,
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              nibble_en,
    input  logic              edo_en,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              timing_err
);
    // ---------------- strobe sampling ----------------
    logic [STB_N-1:0] stb_n, stb_q, stb_fall;
    logic             ras_q, cas_q, ras_fall, cas_fall, ras_rise;

    assign stb_n[STB_RAS] = ras_n;
    assign stb_n[STB_CAS] = cas_n;

    mxd_edge #(.N(STB_N)) u_edge (
        .clk   (clk),
        .rst   (rst),
        .sig_n (stb_n),
        .q_n   (stb_q),
        .fall  (stb_fall)
    );

    assign ras_q    = stb_q[STB_RAS];
    assign cas_q    = stb_q[STB_CAS];
    assign ras_fall = stb_fall[STB_RAS];
    assign cas_fall = stb_fall[STB_CAS];
    assign ras_rise = ras_n & ~ras_q;

    // ---------------- timing windows ----------------
    logic pre_ready, rcd_ready;
    strobe_dec_t dec;

    mxd_gap_timer #(.LIMIT(T_RP)) u_precharge (
        .clk   (clk),
        .rst   (rst),
        .load  (ras_rise),
        .ready (pre_ready)
    );

    mxd_gap_timer #(.LIMIT(T_RCD)) u_row_to_col (
        .clk   (clk),
        .rst   (rst),
        .load  (dec.ras_ok),
        .ready (rcd_ready)
    );

    // ---------------- row state ----------------
    logic             row_open;
    logic [ROW_W-1:0] open_row;

    always_comb begin
        dec.ras_ok    = ras_fall & pre_ready;
        dec.ras_bad   = ras_fall & ~pre_ready;
        dec.cas_early = cas_fall & ~ras_n & (ras_fall | (row_open & ~rcd_ready));
        dec.cas_acc   = cas_fall & ~ras_n & ~ras_fall & row_open & rcd_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row_open <= 1'b0;
            open_row <= '0;
        end else if (ras_n) begin
            row_open <= 1'b0;
        end else if (dec.ras_ok) begin
            row_open <= 1'b1;
            open_row <= addr[ROW_W-1:0];
        end
    end

    // ---------------- column selection ----------------
    logic [COL_W-1:0] last_col, nib_col, col_sel;
    logic [1:0]       nib_cnt;

    if (COL_W > 2) begin : g_nib_wide
        assign nib_col = {last_col[COL_W-1:2], nib_wrap_inc(last_col[1:0])};
    end else begin : g_nib_narrow
        assign nib_col = nib_wrap_inc(last_col[1:0]);
    end

    assign col_sel = (nibble_en && nib_cnt != 2'd0) ? nib_col : addr[COL_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            nib_cnt  <= 2'd0;
            last_col <= '0;
        end else begin
            if (dec.ras_ok)       nib_cnt <= 2'd0;
            else if (dec.cas_acc) nib_cnt <= nibble_en ? nib_cnt + 2'd1 : 2'd0;
            if (dec.cas_acc)      last_col <= col_sel;
        end
    end

    // ---------------- access ----------------
    acc_kind_t         kind;
    logic [DATA_W-1:0] rdata;

    always_comb begin
        if (!dec.cas_acc) kind = ACC_IDLE;
        else if (we_n)    kind = ACC_READ;
        else              kind = ACC_WRITE;
    end

    mxd_cell_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_cells (
        .clk   (clk),
        .rst   (rst),
        .wr_en (kind == ACC_WRITE),
        .rd_en (kind == ACC_READ),
        .row   (open_row),
        .col   (col_sel),
        .wdata (dq_in),
        .rdata (rdata)
    );

    // ---------------- output hold ----------------
    logic rd_valid;

    always_ff @(posedge clk) begin
        if (rst)                     rd_valid <= 1'b0;
        else if (ras_n)              rd_valid <= 1'b0;
        else if (kind != ACC_IDLE)   rd_valid <= (kind == ACC_READ);
        else if (!edo_en && cas_n)   rd_valid <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) timing_err <= 1'b0;
        else     timing_err <= timing_err | dec.ras_bad | dec.cas_early;
    end

    assign dq_oe  = rd_valid & ~oe_n;
    assign dq_out = rd_valid ? rdata : '0;

endmodule

// File: rtl/mxdram_emu_chk.sv
module mxdram_emu_chk (
    input logic clk,
    input logic rst,
    input logic ras_n,
    input logic cas_n,
    input logic edo_en,
    input logic ras_q,
    input logic cas_q,
    input logic dq_oe,
    input logic timing_err
);
    AST_RAS_HIGH_DROPS_DATA: assert property (@(posedge clk) disable iff (rst)
        ras_n |=> !dq_oe) else $error("row high kept data");                    // R4

    AST_STD_CAS_HIGH_DROPS: assert property (@(posedge clk) disable iff (rst)
        (!edo_en && cas_n) |=> !dq_oe) else $error("column high kept data");     // R4

    AST_SAME_EDGE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (ras_q && !ras_n && cas_q && !cas_n) |=> timing_err)
        else $error("coincident strobe falls not flagged");                       // R9

    AST_CAS_ROW_HIGH_QUIET: assert property (@(posedge clk) disable iff (rst)
        (ras_n && cas_q && !cas_n && !timing_err) |=> (!timing_err && !dq_oe))
        else $error("column fall with row high had an effect");                   // R10

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        timing_err |=> timing_err) else $error("error flag dropped");             // R11
endmodule

bind mxdram_emu mxdram_emu_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .edo_en     (edo_en),
    .ras_q      (ras_q),
    .cas_q      (cas_q),
    .dq_oe      (dq_oe),
    .timing_err (timing_err)
);

// File: tb/mxdram_emu_tb_top.sv
`timescale 1ns/1ps
module mxdram_emu_tb_top;
    localparam int ROW_W = 4, COL_W = 4, DATA_W = 8, T_RP = 3, T_RCD = 2;
    localparam int NCOL = 1 << COL_W, NROW = 1 << ROW_W;

    logic clk = 1'b0, rst = 1'b1;
    logic [3:0] addr = '0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
    logic nibble_en = 1'b0, edo_en = 1'b0;
    logic [7:0] dq_in = '0;
    wire  [7:0] dq_out;
    wire        dq_oe, timing_err;

    always #2.5 clk = ~clk;

    mxdram_emu #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
                 .T_RP(T_RP), .T_RCD(T_RCD)) dut_i (
        .clk(clk), .rst(rst), .addr(addr), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .oe_n(oe_n), .nibble_en(nibble_en), .edo_en(edo_en),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .timing_err(timing_err));

    int    vectors = 0, misses = 0;
    bit    finished = 0;
    string cur_req = "R11";

    // ---------------- behavioural reference ----------------
    int m_mem [NROW*NCOL];
    bit m_prev_ras = 1, m_prev_cas = 1, m_open = 0, m_valid = 0, m_err = 0;
    int m_hi_run = T_RP, m_row = 0, m_since = 0, m_nib = 0, m_last = 0, m_data = 0;

    always @(posedge clk) begin : ref_model
        bit rf, cf, acc;
        int col;
        if (rst) begin
            m_prev_ras = 1; m_prev_cas = 1; m_open = 0; m_valid = 0; m_err = 0;
            m_hi_run = T_RP; m_since = 0; m_nib = 0; m_last = 0; m_data = 0;
        end else begin
            rf  = m_prev_ras && !ras_n;
            cf  = m_prev_cas && !cas_n;
            acc = 0;
            if (m_open) m_since++;
            if (rf) begin
                if (m_hi_run >= T_RP) begin
                    m_open = 1; m_row = int'(addr); m_since = 0; m_nib = 0;
                end else m_err = 1;
            end
            if (cf && !ras_n) begin
                if (rf || (m_open && m_since < T_RCD)) m_err = 1;
                else if (m_open) begin
                    acc = 1;
                    if (nibble_en && m_nib != 0) col = (m_last & ~3) | ((m_last + 1) & 3);
                    else                         col = int'(addr);
                    m_last = col;
                    m_nib  = nibble_en ? (m_nib + 1) % 4 : 0;
                    if (!we_n) begin
                        m_mem[m_row*NCOL + col] = int'(dq_in);
                        m_valid = 0;
                    end else begin
                        m_valid = 1;
                        m_data  = m_mem[m_row*NCOL + col];
                    end
                end
            end
            if (ras_n) begin m_valid = 0; m_open = 0; end
            else if (!acc && !edo_en && cas_n) m_valid = 0;
            if (ras_n) m_hi_run = m_prev_ras ? ((m_hi_run < 1000) ? m_hi_run + 1 : 1000) : 1;
            m_prev_ras = ras_n;
            m_prev_cas = cas_n;
        end
    end

    // ---------------- checking ----------------
    task automatic check_now();
        bit       e_oe;
        bit [7:0] e_out;
        e_oe  = m_valid && !oe_n;
        e_out = m_valid ? 8'(m_data) : 8'h00;
        vectors++;
        if (dq_oe !== e_oe || dq_out !== e_out || timing_err !== m_err) begin
            misses++;
            $display("FAIL %s: oe/out/err actual %b/%h/%b expected %b/%h/%b at %0t",
                     cur_req, dq_oe, dq_out, timing_err, e_oe, e_out, m_err, $time);
        end
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            check_now();
        end
    endtask

    task automatic do_reset();
        rst = 1; ras_n = 1; cas_n = 1; we_n = 1;
        cyc(2);
        rst = 0;
        cyc(1);
    endtask

    task automatic open_row(int r);
        addr = 4'(r); ras_n = 0;
        cyc(T_RCD);
    endtask

    task automatic close_row();
        ras_n = 1; cas_n = 1; we_n = 1;
        cyc(T_RP);
    endtask

    task automatic cas_op(int c, bit wr, int d);
        addr = 4'(c); we_n = !wr; dq_in = 8'(d); cas_n = 0;
        cyc(2);
        cas_n = 1; we_n = 1;
        cyc(1);
    endtask

    function automatic int pat(int r, int c);
        return ((r * 16 + c) ^ 8'hA5) & 8'hFF;
    endfunction

    initial begin
        // reset state
        cur_req = "R11";
        do_reset();
        cyc(2);

        // fill array with page writes
        cur_req = "R1 R2 R5";
        for (int r = 0; r < NROW; r++) begin
            open_row(r);
            for (int c = 0; c < NCOL; c++) cas_op(c, 1, pat(r, c));
            close_row();
        end

        // page reads, output enable and standard withdrawal
        cur_req = "R3 R4 R5";
        open_row(3);
        cas_op(0, 0, 0); cas_op(5, 0, 0); cas_op(15, 0, 0);
        oe_n = 1; cas_op(9, 0, 0); oe_n = 0;
        cas_op(9, 0, 0);
        close_row();

        // nibble sequencing
        cur_req = "R6";
        nibble_en = 1;
        open_row(7);
        cas_op(6, 0, 0); cas_op(0, 0, 0); cas_op(11, 0, 0); cas_op(2, 0, 0);
        cas_op(9, 0, 0); cas_op(3, 0, 0);
        close_row();
        open_row(8);
        cas_op(13, 1, 8'h61); cas_op(1, 1, 8'h62); cas_op(2, 1, 8'h63); cas_op(3, 1, 8'h64);
        close_row();
        nibble_en = 0;
        open_row(8);
        cas_op(12, 0, 0); cas_op(13, 0, 0); cas_op(14, 0, 0); cas_op(15, 0, 0); cas_op(1, 0, 0);
        close_row();

        // extended output hold
        cur_req = "R7";
        edo_en = 1;
        open_row(4);
        cas_op(2, 0, 0); cyc(3);
        cas_op(6, 0, 0); cyc(2);
        cas_op(6, 1, 8'h3C); cyc(2);
        cas_op(6, 0, 0); cyc(2);
        close_row();
        cyc(2);
        edo_en = 0;

        // precharge violation
        cur_req = "R8";
        open_row(2);
        cas_op(1, 0, 0);
        ras_n = 1; cas_n = 1;
        cyc(T_RP - 1);
        addr = 4'd9; ras_n = 0;
        cyc(T_RCD + 1);
        cas_op(4, 1, 8'hEE);
        cur_req = "R11";
        close_row(); cyc(4);
        do_reset();
        cur_req = "R8";
        open_row(9); cas_op(4, 0, 0); close_row();

        // row-to-column violations
        cur_req = "R9";
        addr = 4'd5; ras_n = 0;
        cyc(1);
        addr = 4'd3; we_n = 0; dq_in = 8'hEE; cas_n = 0;
        cyc(2);
        cas_n = 1; we_n = 1; cyc(1);
        cas_op(3, 0, 0);
        close_row();
        do_reset();
        addr = 4'd6; ras_n = 0; we_n = 0; dq_in = 8'hDD; cas_n = 0;
        cyc(2);
        cas_n = 1; we_n = 1; cyc(1);
        close_row();
        do_reset();
        open_row(5); cas_op(3, 0, 0); close_row();
        open_row(6); cas_op(6, 0, 0); close_row();

        // column fall with row high
        cur_req = "R10";
        cas_op(7, 1, 8'h11);
        cas_op(7, 0, 0);
        cyc(2);
        open_row(0); cas_op(7, 0, 0); close_row();

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            misses++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule